// File: doc/BRIEF.md
# Multiply-Subtract Engine with Running Carry

This block performs the inner step of multi-word long division. It subtracts a scalar quotient guess times a multi-word divisor from a multi-word minuend, one word per clock cycle. Words enter least significant first. Every element of a sequence uses the same scalar. A single W-bit carry register links one element to the next. The carry is an offset-encoded borrow: a value of 1 means no borrow, 0 means a borrow of one, and larger values wrap modulo 2^W to encode larger borrows.

Each accepted step forms a 2W-bit sum from three terms: the zero-extended minuend word, the bitwise inverse of the 2W-bit product (scalar times divisor word), and the current carry. The low half of the sum is the result word. The high half becomes the next carry. When the incoming carry is 0 or 1, that high half is first incremented by one.

A dedicated init strobe presets the carry to 1 and latches the element count. The sequencer then accepts exactly that many steps. Estimating the quotient and adding the divisor back after an over-subtraction are left to the surrounding logic.

Top module: `mulsub_carry_unit`

## Requirements
- R1: After reset, `carry_o` is 0, `res_valid_o` is 0 and `last_o` is 0, and no step is accepted until an init.
- R2: `init_i` loads the carry with 1, latches `vl_i`, and restarts the element index at 0. It takes priority over `step_i` in the same cycle: that step produces no result, sets no `res_valid_o`, and does not count towards the sequence.
- R3: One cycle after an accepted step, `res_o` holds the low W bits of minuend + ~(scalar*divisor) + carry, with the product taken to 2W bits, and `res_valid_o` is 1. With borrow b encoded in the incoming carry, this equals (minuend - scalar*divisor - b) mod 2^W.
- R4: After an accepted step, the new carry is the high W bits of that 2W-bit sum. One is added to it when the incoming carry is at most 1, under an unsigned compare. The new carry equals (1 - b') mod 2^W, where b' is the borrow out of the element.
- R5: After init and vl accepted steps, the result words, read least significant first, equal (minuend - scalar*divisor) mod 2^(W*vl). This holds for every scalar value, including 0 and all-ones.
- R6: The sequence accepts exactly vl steps. `last_o` is 1 in the cycle after the vl-th step. Steps outside an open sequence leave `res_o` and `carry_o` unchanged and keep `res_valid_o` at 0.
- R7: An init with `vl_i` equal to 0 opens no sequence, so subsequent steps are ignored as in R6.
- R8: A cycle without `step_i` holds the carry and drops `res_valid_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Preset carry to 1 and start a sequence of `vl_i` elements |
| vl_i | input | VLW | Element count for the next sequence |
| step_i | input | 1 | Element words are valid this cycle |
| minuend_i | input | W | Minuend word of the current element |
| divisor_i | input | W | Divisor word of the current element |
| scalar_i | input | W | Scalar multiplier, the same for every element |
| res_o | output | W | Result word of the last accepted step |
| res_valid_o | output | 1 | `res_o` was updated by the previous cycle's step |
| last_o | output | 1 | The previous step was the final element of the sequence |
| carry_o | output | W | Current carry register |

## Verification
Some behaviours are checked by assertions on every cycle:
- an init leaves the carry at 1;
- the element index stays below the latched count while a sequence is open;
- a completed sequence is closed;
- an idle carry stays stable;
- a zero scalar with a no-borrow carry passes the minuend word through and keeps the carry at 1.

The arithmetic of R3 to R5 can be shown only by the bench's scenarios. The bench models each element's borrow and checks every result word and carry, including cases where the carry grows past 1. It also compares the assembled multi-word result against a full-width subtraction. Init priority, zero-length sequences and steps that arrive after the final element are likewise exercised as scenarios.

// File: rtl/msc_pkg.sv
package msc_pkg;
  // carry value that encodes "no borrow pending"
  function automatic int unsigned no_borrow_carry();
    return 1;
  endfunction
endpackage

// File: rtl/msc_prod_sum.sv
// Combinational core: zero-extended minuend plus inverted double-width
// product plus carry-in, split into high and low halves.
module msc_prod_sum #(
  parameter int W = 64
) (
  input  logic [W-1:0] minuend_i,
  input  logic [W-1:0] divisor_i,
  input  logic [W-1:0] scalar_i,
  input  logic [W-1:0] carry_i,
  output logic [W-1:0] sum_hi_o,
  output logic [W-1:0] sum_lo_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] prod;
  logic [DW-1:0] sum;

  always_comb begin
    prod = DW'(scalar_i) * DW'(divisor_i);
    sum  = {{W{1'b0}}, minuend_i} + ~prod + {{W{1'b0}}, carry_i};
  end

  assign sum_hi_o = sum[DW-1:W];
  assign sum_lo_o = sum[W-1:0];
endmodule

// File: rtl/msc_carry_next.sv
// Next carry: high half, bumped by one when the incoming carry is 0 or 1.
module msc_carry_next #(
  parameter int W = 64
) (
  input  logic [W-1:0] carry_i,
  input  logic [W-1:0] sum_hi_i,
  output logic [W-1:0] carry_o
);
  logic small_in;

  always_comb begin
    small_in = (carry_i <= W'(1));
    carry_o  = small_in ? (sum_hi_i + W'(1)) : sum_hi_i;
  end
endmodule

// File: rtl/msc_seq.sv
// Element sequencer: opens on init, accepts vl steps, then closes.
module msc_seq #(
  parameter int VL_MAX = 8,
  localparam int VLW = $clog2(VL_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_i,
  input  logic [VLW-1:0] vl_i,
  input  logic           step_i,
  output logic           accept_o,
  output logic           final_o,
  output logic           active_o
);
  logic           active_q, active_d;
  logic [VLW-1:0] idx_q, idx_d;
  logic [VLW-1:0] vl_q, vl_d;
  logic           final_step;

  always_comb begin
    accept_o   = step_i && active_q && !init_i;
    final_step = accept_o && (idx_q == vl_q - VLW'(1));
    active_d   = active_q;
    idx_d      = idx_q;
    vl_d       = vl_q;
    if (init_i) begin
      active_d = (vl_i != '0);
      idx_d    = '0;
      vl_d     = vl_i;
    end else if (accept_o) begin
      idx_d = final_step ? '0 : idx_q + VLW'(1);
      if (final_step) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      vl_q     <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      vl_q     <= vl_d;
    end
  end

  assign final_o  = final_step;
  assign active_o = active_q;

  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (idx_q < vl_q));

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && vl_i == '0) |=> !active_q);
endmodule

// File: rtl/mulsub_carry_unit.sv
module mulsub_carry_unit #(
  parameter int W      = 64,
  parameter int VL_MAX = 8,
  localparam int VLW   = $clog2(VL_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_i,
  input  logic [VLW-1:0] vl_i,
  input  logic           step_i,
  input  logic [W-1:0]   minuend_i,
  input  logic [W-1:0]   divisor_i,
  input  logic [W-1:0]   scalar_i,
  output logic [W-1:0]   res_o,
  output logic           res_valid_o,
  output logic           last_o,
  output logic [W-1:0]   carry_o
);
  import msc_pkg::*;

  logic           accept, final_step, active;
  logic [W-1:0]   sum_hi, sum_lo, carry_nx;
  logic [W-1:0]   carry_q, carry_d;
  logic [W-1:0]   res_q, res_d;
  logic           valid_q, valid_d;
  logic           last_q, last_d;

  msc_seq #(.VL_MAX(VL_MAX)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (init_i),
    .vl_i     (vl_i),
    .step_i   (step_i),
    .accept_o (accept),
    .final_o  (final_step),
    .active_o (active)
  );

  msc_prod_sum #(.W(W)) u_core (
    .minuend_i (minuend_i),
    .divisor_i (divisor_i),
    .scalar_i  (scalar_i),
    .carry_i   (carry_q),
    .sum_hi_o  (sum_hi),
    .sum_lo_o  (sum_lo)
  );

  msc_carry_next #(.W(W)) u_cnext (
    .carry_i  (carry_q),
    .sum_hi_i (sum_hi),
    .carry_o  (carry_nx)
  );

  always_comb begin
    carry_d = carry_q;
    res_d   = res_q;
    valid_d = 1'b0;
    last_d  = 1'b0;
    if (init_i) begin
      carry_d = W'(no_borrow_carry());
    end else if (accept) begin
      carry_d = carry_nx;
      res_d   = sum_lo;
      valid_d = 1'b1;
      last_d  = final_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      carry_q <= carry_d;
      res_q   <= res_d;
      valid_q <= valid_d;
      last_q  <= last_d;
    end
  end

  assign res_o       = res_q;
  assign res_valid_o = valid_q;
  assign last_o      = last_q;
  assign carry_o     = carry_q;

  assert_init_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (carry_q == W'(1)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !init_i) |=> ($stable(carry_q) && !valid_q));

  assert_closed_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> !active);

  assert_zero_scalar_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && scalar_i == '0 && carry_q == W'(1))
      |=> (carry_q == W'(1) && res_q == $past(minuend_i)));
endmodule

// File: tb/mulsub_carry_unit_tb.sv
module mulsub_carry_unit_tb;
  localparam int W = 4;
  localparam int VL_MAX = 4;
  localparam int VLW = $clog2(VL_MAX + 1);
  localparam int MASK = (1 << W) - 1;

  logic clk, rst_n, init_i, step_i;
  logic [VLW-1:0] vl_i;
  logic [W-1:0] minuend_i, divisor_i, scalar_i;
  logic [W-1:0] res_o, carry_o;
  logic res_valid_o, last_o;

  int checks = 0;
  int fails = 0;

  mulsub_carry_unit #(.W(W), .VL_MAX(VL_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .vl_i(vl_i), .step_i(step_i),
    .minuend_i(minuend_i), .divisor_i(divisor_i), .scalar_i(scalar_i),
    .res_o(res_o), .res_valid_o(res_valid_o), .last_o(last_o), .carry_o(carry_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_init(input int vl, input bit with_step);
    @(negedge clk);
    init_i = 1'b1; vl_i = VLW'(vl); step_i = with_step;
    minuend_i = 4'h9; divisor_i = 4'h3; scalar_i = 4'h2;
    @(posedge clk); #2;
    init_i = 1'b0; step_i = 1'b0;
    chk("R2 carry preset", carry_o, 1);
    chk("R2 no result on init", res_valid_o, 0);
  endtask

  task automatic one_step(input int n, input int d, input int q);
    @(negedge clk);
    step_i = 1'b1;
    minuend_i = W'(n); divisor_i = W'(d); scalar_i = W'(q);
    @(posedge clk); #2;
    step_i = 1'b0;
  endtask

  // runs a whole sequence and checks each element plus the assembled value
  task automatic run_seq(input int vl, input int q, input int nw[VL_MAX], input int dw[VL_MAX]);
    int borrow;
    longint bign, bigd, bigr, expv, mask_all;
    borrow = 0; bign = 0; bigd = 0; bigr = 0;
    do_init(vl, 1'b0);
    for (int k = 0; k < vl; k++) begin
      int diff, nb;
      one_step(nw[k], dw[k], q);
      diff = nw[k] - q * dw[k] - borrow;
      nb = (diff < 0) ? ((-diff + MASK) >>> W) : 0;
      chk("R3 result word", res_o, diff & MASK);
      chk("R4 carry", carry_o, (1 - nb) & MASK);
      chk("R6 last flag", last_o, (k == vl - 1) ? 1 : 0);
      borrow = nb;
      bign = bign | (longint'(nw[k]) << (W * k));
      bigd = bigd | (longint'(dw[k]) << (W * k));
      bigr = bigr | (longint'(res_o) << (W * k));
    end
    mask_all = (longint'(1) << (W * vl)) - 1;
    expv = (bign - longint'(q) * bigd) & mask_all;
    chk("R5 full result", bigr, expv);
  endtask

  initial begin : watchdog
    #3000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int nw[VL_MAX];
    int dw[VL_MAX];
    int held_res, held_carry;
    rst_n = 1'b0; init_i = 1'b0; step_i = 1'b0; vl_i = '0;
    minuend_i = '0; divisor_i = '0; scalar_i = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset carry", carry_o, 0);
    chk("R1 reset valid", res_valid_o, 0);
    chk("R1 reset last", last_o, 0);
    @(negedge clk); rst_n = 1'b1;
    one_step(5, 3, 2);
    chk("R1 step before init ignored", res_valid_o, 0);
    chk("R1 carry untouched", carry_o, 0);

    // sweep every scalar with several word patterns, vl = 3
    for (int q = 0; q <= MASK; q++) begin
      for (int s = 0; s < 6; s++) begin
        for (int k = 0; k < VL_MAX; k++) begin
          nw[k] = (s == 0) ? 0 : (s == 1) ? MASK : ((q * 7 + s * 5 + k * 11) & MASK);
          dw[k] = (s == 2) ? MASK : (s == 3) ? 0 : ((q * 3 + s * 13 + k * 9 + 1) & MASK);
        end
        run_seq(3, q, nw, dw);
      end
    end

    // full-length and single-element sequences
    for (int k = 0; k < VL_MAX; k++) begin nw[k] = 0; dw[k] = MASK; end
    run_seq(VL_MAX, MASK, nw, dw);
    for (int k = 0; k < VL_MAX; k++) begin nw[k] = (k * 5 + 2) & MASK; dw[k] = (k * 7 + 3) & MASK; end
    run_seq(VL_MAX, 9, nw, dw);
    run_seq(1, 13, nw, dw);

    // R6: steps after the final element are ignored
    held_res = res_o; held_carry = carry_o;
    one_step(7, 7, 7);
    chk("R6 extra step no valid", res_valid_o, 0);
    chk("R6 extra step res held", res_o, held_res);
    chk("R6 extra step carry held", carry_o, held_carry);

    // R2: init with a simultaneous step; the sequence still takes vl steps
    do_init(2, 1'b1);
    one_step(4, 1, 1);
    chk("R2 first counted step", res_valid_o, 1);
    chk("R2 not last yet", last_o, 0);
    chk("R3 word after priority", res_o, 3);
    one_step(0, 0, 1);
    chk("R2 second step is last", last_o, 1);

    // R8: idle cycle holds carry and clears valid
    do_init(2, 1'b0);
    one_step(0, 1, 1);
    held_carry = carry_o;
    @(negedge clk); @(posedge clk); #2;
    chk("R8 idle carry held", carry_o, held_carry);
    chk("R8 idle valid low", res_valid_o, 0);

    // R7: zero-length sequence
    do_init(0, 1'b0);
    one_step(6, 2, 3);
    chk("R7 zero length ignores step", res_valid_o, 0);
    chk("R7 carry held", carry_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule